// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Programmable Flags

This block is an 18-bit wide FIFO whose write port and read port run on unrelated clocks. The depth `DEPTH` is a small power of two (64 by default). The write and read counters cross between the two clock domains as Gray codes through two-flop synchronisers.

The read port has two timing modes, and the value of `mode_sel` picks one while `mst_rst` is held. In standard mode a read strobe fetches a word into the output register, and the word is valid after the next read clock edge. In first-word-fall-through mode the output register is an extra storage stage. The oldest word shows on `rd_data` with no strobe, the FIFO then holds up to `DEPTH+1` words, and every flag threshold moves to match.

Besides the full and empty indications, the block drives an almost-full flag, an almost-empty flag and a half-full flag. The almost-full flag uses offset m and the almost-empty flag uses offset n. Both offsets are registers written through a parallel load port. A partial reset empties the FIFO and keeps both the mode and the offsets. A master reset also puts both offsets back to 7.

Top module: `dual_mode_fifo`

## Requirements
- R1: `mode_sel` is taken only while `mst_rst` is high (0 = standard, 1 = fall-through). After a master reset in standard mode `wr_flag`=1 and `rd_flag`=0. In fall-through mode `wr_flag`=0 and `rd_flag`=1. In both modes `pae_n`=0, `paf_n`=1 and `hf_n`=1.
- R2: Words leave in the order they were written. In standard mode a word read by a strobe that `rd_flag`=1 accepts is on `rd_data` after that read clock edge. In fall-through mode the oldest word is on `rd_data` with no strobe while `rd_flag`=0, and it stays there until a strobe consumes it.
- R3: A write is accepted only when the FIFO is not full, and other writes are ignored. `wr_flag` means "full" when it is 0 in standard mode, after `DEPTH` unread writes. In fall-through mode it means "full" when it is 1, after `DEPTH+1` unread writes. It changes on the write clock edge of the write that fills the FIFO.
- R4: A read strobe is ignored when no word is available, which is `rd_flag`=0 in standard mode and `rd_flag`=1 in fall-through mode.
- R5: `paf_n` is low when the stored word count is at least (`DEPTH`−m) in standard mode or (`DEPTH`+1−m) in fall-through mode. It is updated on the write clock edge.
- R6: `pae_n` is low when the stored word count is at most n in standard mode or n+1 in fall-through mode. It is updated on the read clock.
- R7: `hf_n` goes low on the write edge that takes the count above `DEPTH`/2 in standard mode or above `DEPTH`/2+1 in fall-through mode. With no reads, that is after `DEPTH`/2+1 or `DEPTH`/2+2 writes.
- R8: `hf_n` goes high on the read clock edge of the read that brings the count back to `DEPTH`/2 (standard) or `DEPTH`/2+1 (fall-through).
- R9: When `ofs_ld` is high on a write clock edge, `ofs_val` is written to m if `ofs_sel`=0 and to n if `ofs_sel`=1. The new value moves the R5 and R6 thresholds.
- R10: `prt_rst` empties the FIFO and sets the flags as in R1, but it keeps the selected mode and the loaded offsets.
- R11: `mst_rst` sets both m and n back to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mst_rst | input | 1 | Master reset, active high, asynchronous; mode sampled while high |
| prt_rst | input | 1 | Partial reset, active high, asynchronous |
| mode_sel | input | 1 | Read timing mode to latch at master reset (1 = fall-through) |
| wr_en | input | 1 | Write strobe (wclk) |
| wr_data | input | 18 | Write data |
| ofs_ld | input | 1 | Offset load strobe (wclk) |
| ofs_sel | input | 1 | Offset select: 0 = m (full side), 1 = n (empty side) |
| ofs_val | input | 6 | Offset value to load |
| rd_en | input | 1 | Read strobe (rclk) |
| rd_data | output | 18 | Output data register |
| wr_flag | output | 1 | Full (active low) in standard mode, input-busy (high) in fall-through |
| rd_flag | output | 1 | Empty (active low) in standard mode, no-data (high) in fall-through |
| paf_n | output | 1 | Almost-full, active low |
| pae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low, driven from both clock domains |

## Verification
`wr_flag`, `paf_n` and a rising half-full condition all change on the write edge that causes them, so the bench samples them on the falling write edge right after that write. `pae_n`, `rd_flag` and fall-through data react to writes only after the two synchroniser stages and one flag register, which is three read clocks. The bench waits eight read clocks before it checks them. Standard-mode data and the clearing of half-full appear at the read edge that accepts the strobe, so the scoreboard monitor compares one nanosecond after that edge, and fall-through data is captured on the falling edge before the consuming edge.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;
  typedef enum logic {OFS_FULL = 1'b0, OFS_EMPTY = 1'b1} ofs_sel_e;

  localparam int unsigned OFS_DEFAULT = 7;

  // words the FIFO can hold: the output stage adds one in fall-through mode
  function automatic int unsigned cap_words(input int unsigned depth, input bit fwft);
    return depth + (fwft ? 1 : 0);
  endfunction

  // count at or above which almost-full is asserted
  function automatic int unsigned paf_limit(input int unsigned depth, input bit fwft,
                                            input int unsigned m);
    return cap_words(depth, fwft) - m;
  endfunction

  // count at or below which almost-empty is asserted
  function automatic int unsigned pae_limit(input bit fwft, input int unsigned n);
    return n + (fwft ? 1 : 0);
  endfunction

  // count above which half-full is asserted
  function automatic int unsigned hf_limit(input int unsigned depth, input bit fwft);
    return depth / 2 + (fwft ? 1 : 0);
  endfunction

endpackage

// File: rtl/fifo_sync2.sv
`timescale 1ns/1ps
module fifo_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
module fifo_mem #(
  parameter int unsigned W  = 18,
  parameter int unsigned AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned ENTRIES = 1 << AW;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6,
  parameter int unsigned PW    = AW + 2
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          mode_fwft,
  input  logic          wr_en,
  input  logic [AW-1:0] ofs_m,
  input  logic [PW-1:0] rptr_gs,
  input  logic [PW-1:0] uptr_gs,
  output logic [PW-1:0] wptr_g,
  output logic [AW-1:0] waddr,
  output logic          wr_ok,
  output logic          full_q,
  output logic          paf_q,
  output logic          hf_w
);
  localparam logic [PW-1:0] RAM_LIM = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] wptr, wptr_n, rptr_s, uptr_s;
  logic [PW-1:0] tot_n, ram_n;
  logic [PW-1:0] cap_lim, paf_lim, hf_lim;
  logic          full_n, paf_n_int, hf_n_int;

  assign rptr_s  = g2b(rptr_gs);
  assign uptr_s  = g2b(uptr_gs);
  assign cap_lim = PW'(fifo_pkg::cap_words(DEPTH, mode_fwft));
  assign paf_lim = PW'(fifo_pkg::paf_limit(DEPTH, mode_fwft, 32'(ofs_m)));
  assign hf_lim  = PW'(fifo_pkg::hf_limit(DEPTH, mode_fwft));

  // named event: write accepted this edge
  assign wr_ok  = wr_en & ~full_q;
  assign wptr_n = wptr + PW'(wr_ok);
  // count including output stage (pessimistic: read side lags)
  assign tot_n  = wptr_n - uptr_s;
  // words held in the array alone
  assign ram_n  = wptr_n - rptr_s;

  assign full_n    = (tot_n >= cap_lim) | (ram_n >= RAM_LIM);
  assign paf_n_int = tot_n >= paf_lim;
  assign hf_n_int  = tot_n > hf_lim;

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      wptr   <= '0;
      wptr_g <= '0;
      full_q <= 1'b0;
      paf_q  <= 1'b0;
      hf_w   <= 1'b0;
    end else begin
      wptr   <= wptr_n;
      wptr_g <= b2g(wptr_n);
      full_q <= full_n;
      paf_q  <= paf_n_int;
      hf_w   <= hf_n_int;
    end
  end

  assign waddr = wptr[AW-1:0];

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && full_q) |=> $stable(wptr_g));

  assert_wr_gray_step_R2: assert property (@(posedge wclk) disable iff (rst)
    $countones(wptr_g ^ $past(wptr_g)) <= 1);

  assert_paf_with_full_R5: assert property (@(posedge wclk) disable iff (rst)
    (full_q && ofs_m != '0) |-> paf_q);
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 18,
  parameter int unsigned AW    = 6,
  parameter int unsigned PW    = AW + 2
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          mode_fwft,
  input  logic          rd_en,
  input  logic [AW-1:0] ofs_n,
  input  logic [PW-1:0] wptr_gs,
  input  logic          hfw_s,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_g,
  output logic [PW-1:0] uptr_g,
  output logic [W-1:0]  dout,
  output logic          empty_q,
  output logic          ovalid,
  output logic          pae_q,
  output logic          hf_rclr
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] rptr, uptr, rptr_n, uptr_n, wptr_s, tot_r_n;
  logic [PW-1:0] pae_lim, hf_lim;
  logic          rd_ok, consume, ram_ne, fetch_f, fetch, pop_user;

  assign wptr_s  = g2b(wptr_gs);
  assign pae_lim = PW'(fifo_pkg::pae_limit(mode_fwft, 32'(ofs_n)));
  assign hf_lim  = PW'(fifo_pkg::hf_limit(DEPTH, mode_fwft));

  // named events
  assign rd_ok    = ~mode_fwft & rd_en & ~empty_q;
  assign consume  = mode_fwft & rd_en & ovalid;
  assign ram_ne   = wptr_s != rptr;
  assign fetch_f  = mode_fwft & ram_ne & (~ovalid | consume);
  assign fetch    = mode_fwft ? fetch_f : rd_ok;
  assign pop_user = mode_fwft ? consume : rd_ok;

  assign rptr_n  = rptr + PW'(fetch);
  assign uptr_n  = uptr + PW'(pop_user);
  assign tot_r_n = wptr_s - uptr_n;
  assign raddr   = rptr[AW-1:0];

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      rptr    <= '0;
      uptr    <= '0;
      rptr_g  <= '0;
      uptr_g  <= '0;
      dout    <= '0;
      empty_q <= 1'b1;
      ovalid  <= 1'b0;
      pae_q   <= 1'b1;
      hf_rclr <= 1'b0;
    end else begin
      rptr    <= rptr_n;
      uptr    <= uptr_n;
      rptr_g  <= b2g(rptr_n);
      uptr_g  <= b2g(uptr_n);
      if (fetch) dout <= mem_rdata;
      empty_q <= wptr_s == rptr_n;
      if (fetch_f)      ovalid <= 1'b1;
      else if (consume) ovalid <= 1'b0;
      pae_q <= tot_r_n <= pae_lim;
      if (!hfw_s)                             hf_rclr <= 1'b0;
      else if (pop_user && tot_r_n <= hf_lim) hf_rclr <= 1'b1;
    end
  end

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rst)
    (!mode_fwft && rd_en && empty_q) |=> $stable(rptr_g));

  assert_fwft_hold_R2: assert property (@(posedge rclk) disable iff (rst)
    (mode_fwft && ovalid && !rd_en) |=> (ovalid && $stable(dout)));

  assert_pae_when_empty_R6: assert property (@(posedge rclk) disable iff (rst)
    (!mode_fwft && empty_q) |-> pae_q);

  assert_rd_gray_step_R2: assert property (@(posedge rclk) disable iff (rst)
    $countones(rptr_g ^ $past(rptr_g)) <= 1);
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 18,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mst_rst,
  input  logic          prt_rst,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          ofs_ld,
  input  logic          ofs_sel,
  input  logic [AW-1:0] ofs_val,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          wr_flag,
  output logic          rd_flag,
  output logic          paf_n,
  output logic          pae_n,
  output logic          hf_n
);
  localparam int unsigned PW = AW + 2;
  localparam logic [AW-1:0] OFS_DEF = AW'(fifo_pkg::OFS_DEFAULT);

  logic          rst_any;
  logic          mode_q;
  logic [AW-1:0] ofs_m, ofs_n;
  logic [PW-1:0] wptr_g, rptr_g, uptr_g, wptr_gs, rptr_gs, uptr_gs;
  logic [AW-1:0] waddr, raddr;
  logic [W-1:0]  mem_rdata;
  logic          wr_ok, full_q, paf_q, hf_w, hfw_s;
  logic          empty_q, ovalid, pae_q, hf_rclr;

  assign rst_any = mst_rst | prt_rst;

  // mode is loaded only during master reset; partial reset leaves it alone
  always_ff @(posedge wclk) begin
    if (mst_rst) mode_q <= mode_sel;
  end

  always_ff @(posedge wclk or posedge mst_rst) begin
    if (mst_rst) begin
      ofs_m <= OFS_DEF;
      ofs_n <= OFS_DEF;
    end else if (ofs_ld) begin
      if (ofs_sel == fifo_pkg::OFS_EMPTY) ofs_n <= ofs_val;
      else                                ofs_m <= ofs_val;
    end
  end

  fifo_mem #(.W(W), .AW(AW)) u_mem (
    .wclk(wclk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .rst(rst_any), .mode_fwft(mode_q), .wr_en(wr_en),
    .ofs_m(ofs_m), .rptr_gs(rptr_gs), .uptr_gs(uptr_gs),
    .wptr_g(wptr_g), .waddr(waddr), .wr_ok(wr_ok),
    .full_q(full_q), .paf_q(paf_q), .hf_w(hf_w)
  );

  fifo_rd_ctl #(.DEPTH(DEPTH), .W(W), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rst(rst_any), .mode_fwft(mode_q), .rd_en(rd_en),
    .ofs_n(ofs_n), .wptr_gs(wptr_gs), .hfw_s(hfw_s), .mem_rdata(mem_rdata),
    .raddr(raddr), .rptr_g(rptr_g), .uptr_g(uptr_g), .dout(rd_data),
    .empty_q(empty_q), .ovalid(ovalid), .pae_q(pae_q), .hf_rclr(hf_rclr)
  );

  fifo_sync2 #(.W(PW)) u_sync_w2r (.clk(rclk), .rst(rst_any), .d(wptr_g), .q(wptr_gs));
  fifo_sync2 #(.W(PW)) u_sync_r2w (.clk(wclk), .rst(rst_any), .d(rptr_g), .q(rptr_gs));
  fifo_sync2 #(.W(PW)) u_sync_u2w (.clk(wclk), .rst(rst_any), .d(uptr_g), .q(uptr_gs));
  fifo_sync2 #(.W(1))  u_sync_hf  (.clk(rclk), .rst(rst_any), .d(hf_w),   .q(hfw_s));

  assign wr_flag = mode_q ? full_q : ~full_q;
  assign rd_flag = mode_q ? ~ovalid : ~empty_q;
  assign paf_n   = ~paf_q;
  assign pae_n   = ~pae_q;
  // set from the write domain, released by the read domain
  assign hf_n    = ~(hf_w & ~hf_rclr);
endmodule

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/1ps
module tb_dual_mode_fifo;
  localparam int DEPTH = 64;
  localparam int W     = 18;
  localparam int AW    = 6;

  logic wclk = 0, rclk = 0;
  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  logic          mst_rst = 1, prt_rst = 0, mode_sel = 0;
  logic          wr_en = 0, ofs_ld = 0, ofs_sel = 0, rd_en = 0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] ofs_val = '0;
  logic [W-1:0]  rd_data;
  logic          wr_flag, rd_flag, paf_n, pae_n, hf_n;

  dual_mode_fifo #(.DEPTH(DEPTH), .W(W)) dut (
    .wclk(wclk), .rclk(rclk), .mst_rst(mst_rst), .prt_rst(prt_rst),
    .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data),
    .ofs_ld(ofs_ld), .ofs_sel(ofs_sel), .ofs_val(ofs_val), .rd_en(rd_en),
    .rd_data(rd_data), .wr_flag(wr_flag), .rd_flag(rd_flag),
    .paf_n(paf_n), .pae_n(pae_n), .hf_n(hf_n)
  );

  int nchk = 0, nfail = 0;
  bit fw = 0;
  bit done = 0;
  logic [W-1:0] q[$];
  logic rd_acc_std = 0, rd_acc_fw = 0;
  logic [W-1:0] fw_snap;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    chk(act === exp, req, int'(act), int'(exp));
  endtask

  task automatic wait_r(input int k);
    repeat (k) @(negedge rclk);
  endtask

  task automatic wait_w(input int k);
    repeat (k) @(negedge wclk);
  endtask

  // driver: pushes the expected item when the write will be accepted
  task automatic wr_one(input logic [W-1:0] d);
    @(negedge wclk);
    wr_en = 1; wr_data = d;
    if (fw ? (wr_flag == 1'b0) : (wr_flag == 1'b1)) q.push_back(d);
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic rd_one();
    @(negedge rclk);
    rd_en = 1;
    if (fw) begin
      if (rd_flag == 1'b0) begin rd_acc_fw = 1; fw_snap = rd_data; end
    end else if (rd_flag == 1'b1) rd_acc_std = 1;
    @(negedge rclk);
    rd_en = 0; rd_acc_std = 0; rd_acc_fw = 0;
  endtask

  // monitor: pops the scoreboard as the design delivers words
  always @(posedge rclk) begin
    logic [W-1:0] e;
    if (rd_acc_std || rd_acc_fw) begin
      if (q.size() == 0) chk(0, "R2 unexpected read data", 0, 1);
      else begin
        e = q.pop_front();
        if (rd_acc_std) begin
          #1;
          chk(rd_data === e, "R2 standard read data", int'(rd_data), int'(e));
        end else
          chk(fw_snap === e, "R2 fall-through read data", int'(fw_snap), int'(e));
      end
    end
  end

  task automatic do_mrst(input bit f);
    fw = f; mode_sel = f; mst_rst = 1;
    wait_w(4); wait_r(3);
    @(negedge wclk); mst_rst = 0;
    q.delete();
    wait_r(4);
  endtask

  task automatic do_prst();
    @(negedge wclk); prt_rst = 1;
    wait_w(4); wait_r(3);
    @(negedge wclk); prt_rst = 0;
    q.delete();
    wait_r(4);
  endtask

  task automatic ld_ofs(input logic sel, input logic [AW-1:0] v);
    @(negedge wclk); ofs_ld = 1; ofs_sel = sel; ofs_val = v;
    @(negedge wclk); ofs_ld = 0;
  endtask

  task automatic chk_reset_flags(input string req, input logic wf, input logic rf);
    chk_bit({req, " wr_flag"}, wr_flag, wf);
    chk_bit({req, " rd_flag"}, rd_flag, rf);
    chk_bit({req, " pae_n"}, pae_n, 1'b0);
    chk_bit({req, " paf_n"}, paf_n, 1'b1);
    chk_bit({req, " hf_n"}, hf_n, 1'b1);
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(i * 1031 + 77);
  endfunction

  initial begin
    #150000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // ---------------- standard mode ----------------
    do_mrst(0);
    chk_reset_flags("R1 std reset", 1'b1, 1'b0);

    for (int i = 1; i <= DEPTH; i++) begin
      wr_one(pat(i));
      if (i == 7 || i == 8) begin wait_r(8); chk_bit("R6 std pae", pae_n, i == 8); end
      if (i == 32 || i == 33) chk_bit("R7 std hf set", hf_n, i == 32);
      if (i == 56 || i == 57) chk_bit("R5 std paf", paf_n, i == 56);
      if (i == 63 || i == 64) chk_bit("R3 std full", wr_flag, i == 63);
    end
    wr_one(18'h3FFFF);                  // ignored: full
    chk_bit("R3 std write while full", wr_flag, 1'b0);
    wait_r(8);
    chk_bit("R2 std data present", rd_flag, 1'b1);

    for (int i = 1; i <= 32; i++) begin
      rd_one();
      if (i == 31) chk_bit("R8 std hf still set", hf_n, 1'b0);
      if (i == 32) chk_bit("R8 std hf cleared by read", hf_n, 1'b1);
    end
    wait_w(8);
    chk_bit("R5 std paf released", paf_n, 1'b1);
    for (int i = 1; i <= 32; i++) rd_one();
    chk_bit("R4 std empty", rd_flag, 1'b0);
    rd_one();                           // ignored: empty
    wr_one(18'h00155);
    wait_r(8);
    rd_one();
    chk_bit("R4 std empty after read while empty", rd_flag, 1'b0);

    // ---------------- offsets ----------------
    ld_ofs(1'b0, 6'd3);                 // m
    ld_ofs(1'b1, 6'd2);                 // n
    for (int i = 1; i <= 61; i++) begin
      wr_one(pat(i + 100));
      if (i == 2 || i == 3) begin wait_r(8); chk_bit("R9 loaded n", pae_n, i == 3); end
      if (i == 60 || i == 61) chk_bit("R9 loaded m", paf_n, i == 60);
    end

    // ---------------- partial reset ----------------
    do_prst();
    chk_reset_flags("R10 std partial reset", 1'b1, 1'b0);
    for (int i = 1; i <= 61; i++) begin
      wr_one(pat(i + 200));
      if (i == 60 || i == 61) chk_bit("R10 m kept", paf_n, i == 60);
    end

    // ---------------- fall-through mode ----------------
    do_mrst(1);
    chk_reset_flags("R1 fwft reset", 1'b0, 1'b1);
    wr_one(pat(300));
    wait_r(8);
    chk_bit("R2 fwft first word valid", rd_flag, 1'b0);
    chk(rd_data === pat(300), "R2 fwft first word falls through", int'(rd_data), int'(pat(300)));

    for (int i = 2; i <= DEPTH + 1; i++) begin
      wr_one(pat(300 + i));
      if (i == 8 || i == 9) begin wait_r(8); chk_bit("R6 fwft pae", pae_n, i == 9); end
      if (i == 33 || i == 34) chk_bit("R7 fwft hf set", hf_n, i == 33);
      if (i == 57 || i == 58) chk_bit("R11 default m restored (R5 fwft paf)", paf_n, i == 57);
      if (i == 64 || i == 65) chk_bit("R3 fwft full", wr_flag, i == 65);
    end
    wr_one(18'h3FFFF);                  // ignored: full
    chk_bit("R3 fwft write while full", wr_flag, 1'b1);
    wait_r(8);

    for (int i = 1; i <= DEPTH + 1; i++) begin
      rd_one();
      if (i == 31) chk_bit("R8 fwft hf still set", hf_n, 1'b0);
      if (i == 32) chk_bit("R8 fwft hf cleared by read", hf_n, 1'b1);
    end
    chk_bit("R4 fwft no data", rd_flag, 1'b1);
    rd_one();                           // ignored: empty
    chk(q.size() == 0, "R2 all words delivered", q.size(), 0);

    wr_one(pat(500));
    do_prst();
    chk_bit("R10 fwft mode kept wr_flag", wr_flag, 1'b0);
    chk_bit("R10 fwft mode kept rd_flag", rd_flag, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule